// File: doc/BRIEF.md
# Boot ROM Overlay Shadow Decoder

This block decodes the 24-bit address space of a 32-bit CPU into chip selects for a boot ROM, a large 32-bit RAM, a slow 8-bit legacy region and a control window. With every access it also returns a port-width code. The CPU uses this code to decide whether it must split a wide transfer into several narrower bus cycles.

The decoding changes at run time. Two mode flags are set as a side effect of ordinary bus accesses and are cleared only by reset. Straight after reset, the boot ROM is visible at the bottom of memory so the CPU can fetch its stack pointer (long word at 0) and start address (long word at 4). The same ROM is also visible at a permanent high alias. The start vector points into that alias, so the first instruction fetch has A23 set. That fetch removes the overlay, and from then on the low addresses reach RAM.

Boot software copies the system image from its high window into low RAM. It then touches the control window. That arms write protection: writes to the low 48 KB are acknowledged but dropped, and reads still return RAM. The low RAM then behaves as a fast, wide copy of ROM.

Top module: `shadow_overlay_decoder`

## Requirements
- R1: While the overlay flag is clear (from reset), a valid access to 000000h-00FFFFh selects the boot ROM with port code 2'b10 (16-bit). boot_off equals the low 16 address bits.
- R2: A valid access to FF0000h-FFFFFFh always selects the boot ROM with port code 2'b10. boot_off equals the low 16 address bits, so ROM offset k appears at both 00xxxxh and FFxxxxh.
- R3: A valid access with address bit 23 set sets the overlay flag from the next cycle. After that, 000000h-00FFFFh selects RAM. An address with acc_valid low sets nothing.
- R4: A valid access to F00000h-F3FFFFh, which holds the readable system image at F00000h-F0BFFFh, selects the legacy region with port code 2'b01 (8-bit).
- R5: A valid access to F40000h-FBFFFFh asserts sel_ctrl with port code 2'b11 and sets the write-protect flag from the next cycle.
- R6: While write protect is set, a write to 000000h-00BFFFh asserts wr_dropped with port code 2'b11, and sel_ram and ram_wr stay low. Reads there still select RAM. A write at 00C000h or above is unaffected.
- R7: Otherwise a valid access to 000000h-7FFFFFh selects RAM with port code 2'b11, and ram_wr equals acc_write.
- R8: Valid accesses to 800000h-EFFFFFh and FC0000h-FEFFFFh select nothing and return port code 2'b00 (no acknowledge).
- R9: With acc_valid low, every select, ram_wr and wr_dropped are low and port_code is 2'b00.
- R10: Both flags stay set across any later accesses and are cleared only by rst_n low.
- R11: At most one of sel_boot, sel_ram, sel_legacy, sel_ctrl and wr_dropped is high. The port code is the same for all four byte addresses of an aligned long word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears both mode flags |
| acc_valid | input | 1 | A bus access is present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (24) | Byte address of the access |
| sel_boot | output | 1 | Boot ROM select |
| boot_off | output | BOOT_AW (16) | Byte offset into the boot ROM; zero when sel_boot is low |
| sel_ram | output | 1 | Main RAM select |
| ram_wr | output | 1 | RAM write strobe |
| sel_legacy | output | 1 | 8-bit legacy region select |
| sel_ctrl | output | 1 | Control window hit |
| wr_dropped | output | 1 | Protected write acknowledged without a RAM write |
| port_code | output | 2 | 00 none, 01 8-bit, 10 16-bit, 11 32-bit |

## Verification
A wrong overlay flag shows up at once on the next low-address access. Boot ROM and RAM swap places, and the port code moves between 2'b10 and 2'b11 in the same cycle as the access. A write-protect flag that is stuck or set too early shows up on the first low write after the control access, as a ram_wr pulse where wr_dropped was due, or the other way round. A flag that clears by itself shows up one access later as a reappearing overlay. The stimulus mixes directed boot sequences with random accesses and occasional resets, so each flag is observed in both states and across each set event.

// File: rtl/shadow_map_pkg.sv
package shadow_map_pkg;

  typedef enum logic [2:0] {
    RGN_NONE   = 3'd0,
    RGN_BOOT   = 3'd1,
    RGN_CTRL   = 3'd2,
    RGN_LEGACY = 3'd3,
    RGN_RAM    = 3'd4,
    RGN_DROP   = 3'd5
  } region_e;

  typedef enum logic [1:0] {
    PW_NONE = 2'b00,
    PW_8    = 2'b01,
    PW_16   = 2'b10,
    PW_32   = 2'b11
  } pwidth_e;

  localparam int unsigned FLAG_OVERLAY = 0;
  localparam int unsigned FLAG_WPROT   = 1;
  localparam int unsigned N_FLAGS      = 2;

  // Width reported back to the CPU for each decoded region.
  function automatic pwidth_e width_of(region_e r);
    case (r)
      RGN_BOOT:   return PW_16;
      RGN_LEGACY: return PW_8;
      RGN_RAM:    return PW_32;
      RGN_CTRL:   return PW_32;
      RGN_DROP:   return PW_32;
      default:    return PW_NONE;
    endcase
  endfunction

endpackage

// File: rtl/shadow_mode_flags.sv
module shadow_mode_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flag_o
);

  // One sticky flop per mode; only reset clears them.
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flag_o[g] <= 1'b0;
      else if (set_i[g])
        flag_o[g] <= 1'b1;
    end
  end

endmodule

// File: rtl/shadow_region_decode.sv
module shadow_region_decode
  import shadow_map_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 24,
  parameter int unsigned       BOOT_AW    = 16,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 24'hFF0000,
  parameter logic [ADDR_W-1:0] LEG_LO     = 24'hF00000,
  parameter logic [ADDR_W-1:0] LEG_HI     = 24'hF3FFFF,
  parameter logic [ADDR_W-1:0] CTL_LO     = 24'hF40000,
  parameter logic [ADDR_W-1:0] CTL_HI     = 24'hFBFFFF,
  parameter logic [ADDR_W-1:0] RAM_TOP    = 24'h7FFFFF,
  parameter logic [ADDR_W-1:0] PROT_TOP   = 24'h00BFFF
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic              overlay_on,
  input  logic              wprot_on,
  output region_e           region
);

  localparam int unsigned TAG_W = ADDR_W - BOOT_AW;

  function automatic logic in_span(logic [ADDR_W-1:0] a,
                                   logic [ADDR_W-1:0] lo,
                                   logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic hit_alias, hit_ctrl, hit_leg, hit_low_boot, hit_ram, hit_prot;

  always_comb begin
    hit_alias    = addr[ADDR_W-1:BOOT_AW] == ALIAS_BASE[ADDR_W-1:BOOT_AW];
    hit_ctrl     = in_span(addr, CTL_LO, CTL_HI);
    hit_leg      = in_span(addr, LEG_LO, LEG_HI);
    hit_low_boot = (addr[ADDR_W-1:BOOT_AW] == {TAG_W{1'b0}}) && !overlay_on;
    hit_ram      = addr <= RAM_TOP;
    hit_prot     = (addr <= PROT_TOP) && wprot_on && write;
  end

  // Priority: ROM images, control window, legacy, RAM.
  always_comb begin
    region = RGN_NONE;
    if (valid) begin
      if (hit_alias || hit_low_boot) region = RGN_BOOT;
      else if (hit_ctrl)             region = RGN_CTRL;
      else if (hit_leg)              region = RGN_LEGACY;
      else if (hit_ram)              region = hit_prot ? RGN_DROP : RGN_RAM;
    end
  end

endmodule

// File: rtl/shadow_select_out.sv
module shadow_select_out
  import shadow_map_pkg::*;
#(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned BOOT_AW = 16
) (
  input  region_e             region,
  input  logic                write,
  input  logic [ADDR_W-1:0]   addr,
  output logic                sel_boot,
  output logic [BOOT_AW-1:0]  boot_off,
  output logic                sel_ram,
  output logic                ram_wr,
  output logic                sel_legacy,
  output logic                sel_ctrl,
  output logic                wr_dropped,
  output logic [1:0]          port_code
);

  always_comb begin
    sel_boot   = region == RGN_BOOT;
    sel_ram    = region == RGN_RAM;
    sel_legacy = region == RGN_LEGACY;
    sel_ctrl   = region == RGN_CTRL;
    wr_dropped = region == RGN_DROP;
    ram_wr     = sel_ram && write;
    boot_off   = sel_boot ? addr[BOOT_AW-1:0] : '0;
    port_code  = width_of(region);
  end

endmodule

// File: rtl/shadow_overlay_decoder.sv
module shadow_overlay_decoder
  import shadow_map_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 24,
  parameter int unsigned       BOOT_AW    = 16,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 24'hFF0000,
  parameter logic [ADDR_W-1:0] LEG_LO     = 24'hF00000,
  parameter logic [ADDR_W-1:0] LEG_HI     = 24'hF3FFFF,
  parameter logic [ADDR_W-1:0] CTL_LO     = 24'hF40000,
  parameter logic [ADDR_W-1:0] CTL_HI     = 24'hFBFFFF,
  parameter logic [ADDR_W-1:0] RAM_TOP    = 24'h7FFFFF,
  parameter logic [ADDR_W-1:0] PROT_TOP   = 24'h00BFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [ADDR_W-1:0]  acc_addr,
  output logic               sel_boot,
  output logic [BOOT_AW-1:0] boot_off,
  output logic               sel_ram,
  output logic               ram_wr,
  output logic               sel_legacy,
  output logic               sel_ctrl,
  output logic               wr_dropped,
  output logic [1:0]         port_code
);

  localparam int unsigned HIGH_BIT = ADDR_W - 1;

  region_e            region;
  logic [N_FLAGS-1:0] flag_set;
  logic [N_FLAGS-1:0] flag_q;

  // Named internal events, visible to the bound checker.
  logic overlay_on, wprot_on, set_overlay, set_wprot;

  assign overlay_on  = flag_q[FLAG_OVERLAY];
  assign wprot_on    = flag_q[FLAG_WPROT];
  assign set_overlay = acc_valid && acc_addr[HIGH_BIT];
  assign set_wprot   = region == RGN_CTRL;

  always_comb begin
    flag_set               = '0;
    flag_set[FLAG_OVERLAY] = set_overlay;
    flag_set[FLAG_WPROT]   = set_wprot;
  end

  shadow_mode_flags #(.N(N_FLAGS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .flag_o (flag_q)
  );

  shadow_region_decode #(
    .ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW), .ALIAS_BASE(ALIAS_BASE),
    .LEG_LO(LEG_LO), .LEG_HI(LEG_HI), .CTL_LO(CTL_LO), .CTL_HI(CTL_HI),
    .RAM_TOP(RAM_TOP), .PROT_TOP(PROT_TOP)
  ) u_decode (
    .valid      (acc_valid),
    .write      (acc_write),
    .addr       (acc_addr),
    .overlay_on (overlay_on),
    .wprot_on   (wprot_on),
    .region     (region)
  );

  shadow_select_out #(.ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW)) u_out (
    .region     (region),
    .write      (acc_write),
    .addr       (acc_addr),
    .sel_boot   (sel_boot),
    .boot_off   (boot_off),
    .sel_ram    (sel_ram),
    .ram_wr     (ram_wr),
    .sel_legacy (sel_legacy),
    .sel_ctrl   (sel_ctrl),
    .wr_dropped (wr_dropped),
    .port_code  (port_code)
  );

endmodule

// File: rtl/shadow_overlay_decoder_chk.sv
module shadow_overlay_decoder_chk #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned BOOT_AW  = 16,
  parameter logic [ADDR_W-1:0] PROT_TOP = 24'h00BFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              sel_boot,
  input logic              sel_ram,
  input logic              ram_wr,
  input logic              sel_legacy,
  input logic              sel_ctrl,
  input logic              wr_dropped,
  input logic [1:0]        port_code,
  input logic              overlay_on,
  input logic              wprot_on
);

  localparam int unsigned TAG_W = ADDR_W - BOOT_AW;

  p_low_boot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !overlay_on && acc_addr[ADDR_W-1:BOOT_AW] == {TAG_W{1'b0}})
      |-> (sel_boot && port_code == 2'b10));

  p_overlay_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr[ADDR_W-1]) |=> overlay_on);

  p_wprot_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ctrl |=> wprot_on);

  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && wprot_on && overlay_on && acc_addr <= PROT_TOP)
      |-> (!sel_ram && !ram_wr && wr_dropped && port_code == 2'b11));

  p_ramwr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr |-> (sel_ram && acc_write));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (port_code == 2'b00 && !sel_boot && !sel_ram && !ram_wr
                    && !sel_legacy && !sel_ctrl && !wr_dropped));

  p_overlay_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overlay_on |=> overlay_on);

  p_wprot_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wprot_on |=> wprot_on);

  p_one_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_boot, sel_ram, sel_legacy, sel_ctrl, wr_dropped}));

  p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_code != 2'b00) == (sel_boot || sel_ram || sel_legacy || sel_ctrl || wr_dropped));

endmodule

bind shadow_overlay_decoder shadow_overlay_decoder_chk #(
  .ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW), .PROT_TOP(PROT_TOP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .acc_addr   (acc_addr),
  .sel_boot   (sel_boot),
  .sel_ram    (sel_ram),
  .ram_wr     (ram_wr),
  .sel_legacy (sel_legacy),
  .sel_ctrl   (sel_ctrl),
  .wr_dropped (wr_dropped),
  .port_code  (port_code),
  .overlay_on (overlay_on),
  .wprot_on   (wprot_on)
);

// File: tb/test_shadow_overlay_decoder.sv
`timescale 1ns/1ps
module test_shadow_overlay_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [23:0] acc_addr = '0;
  logic        sel_boot, sel_ram, ram_wr, sel_legacy, sel_ctrl, wr_dropped;
  logic [15:0] boot_off;
  logic [1:0]  port_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit m_ov = 1'b0;
  bit m_wp = 1'b0;

  always #2.5 clk = ~clk;

  shadow_overlay_decoder i_shadow_overlay_decoder (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .sel_boot(sel_boot), .boot_off(boot_off),
    .sel_ram(sel_ram), .ram_wr(ram_wr), .sel_legacy(sel_legacy),
    .sel_ctrl(sel_ctrl), .wr_dropped(wr_dropped), .port_code(port_code)
  );

  // Expected {sel_boot, sel_ram, ram_wr, sel_legacy, sel_ctrl, wr_dropped, code}
  function automatic logic [7:0] expect_of(logic [23:0] a, bit w, bit v, bit ov, bit wp);
    if (!v)                                   return 8'b000000_00;
    if (a[23:16] == 8'hFF)                    return 8'b100000_10;
    if (a >= 24'hF40000 && a < 24'hFC0000)    return 8'b000010_11;
    if (a[23:18] == 6'b111100)                return 8'b000100_01;
    if (!ov && a < 24'h010000)                return 8'b100000_10;
    if (a < 24'h800000) begin
      if (w && wp && a < 24'h00C000)          return 8'b000001_11;
      return {2'b01, w, 3'b000, 2'b11};
    end
    return 8'b000000_00;
  endfunction

  function automatic string tag_of(logic [23:0] a, bit w, bit v, bit ov, bit wp);
    if (!v) return "R9";
    if (a[23:16] == 8'hFF) return "R2";
    if (a >= 24'hF40000 && a < 24'hFC0000) return "R5";
    if (a[23:18] == 6'b111100) return "R4";
    if (!ov && a < 24'h010000) return "R1";
    if (a < 24'h800000) return (wp && a < 24'h00C000) ? "R6" : "R7";
    return "R8";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_acc(string tag, logic [23:0] a, bit w, bit v);
    logic [7:0]  exp;
    logic [15:0] exp_off;
    string t;
    @(negedge clk);
    acc_addr = a; acc_write = w; acc_valid = v;
    #1;
    exp = expect_of(a, w, v, m_ov, m_wp);
    exp_off = exp[7] ? a[15:0] : 16'h0;
    t = (tag == "") ? tag_of(a, w, v, m_ov, m_wp) : tag;
    check(t, {24'h0, sel_boot, sel_ram, ram_wr, sel_legacy, sel_ctrl, wr_dropped, port_code},
          {24'h0, exp});
    check(t, {16'h0, boot_off}, {16'h0, exp_off});
    if (v && a[23]) m_ov = 1'b1;
    if (v && a >= 24'hF40000 && a < 24'hFC0000) m_wp = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; acc_valid = 1'b0;
    m_ov = 1'b0; m_wp = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [23:0] pick_addr(int unsigned r);
    logic [23:0] off;
    off = 24'($urandom) & 24'h00FFFF;
    case (r % 9)
      0: return off;
      1: return 24'h00B000 + (off & 24'h001FFF);
      2: return 24'hFF0000 | off;
      3: return 24'hF00000 | (24'($urandom) & 24'h03FFFF);
      4: return 24'hF40000 + (24'($urandom) % 24'h080000);
      5: return 24'($urandom) & 24'h7FFFFF;
      6: return 24'h800000 + (24'($urandom) % 24'h700000);
      7: return 24'hFC0000 | (24'($urandom) & 24'h02FFFF);
      default: return 24'($urandom);
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R9 idle, R1 reset vectors from boot ROM
    do_acc("R9", 24'h000000, 1'b0, 1'b0);
    do_acc("R1", 24'h000000, 1'b0, 1'b1);
    do_acc("R1", 24'h000004, 1'b0, 1'b1);
    do_acc("R1", 24'h00FFFC, 1'b1, 1'b1);
    // R3: an idle high address must not remove the overlay
    do_acc("R3", 24'hFF0000, 1'b0, 1'b0);
    do_acc("R3", 24'h000008, 1'b0, 1'b1);
    // R2 alias fetch, then R3 low reads hit RAM
    do_acc("R2", 24'hFF0004, 1'b0, 1'b1);
    do_acc("R3", 24'h000000, 1'b0, 1'b1);
    // R11 same width over the four bytes of a long word
    for (int b = 0; b < 4; b++) do_acc("R11", 24'hF00100 + 24'(b), 1'b0, 1'b1);
    for (int b = 0; b < 4; b++) do_acc("R11", 24'hFF0200 + 24'(b), 1'b0, 1'b1);
    do_acc("R4", 24'hF00000, 1'b0, 1'b1);
    do_acc("R4", 24'hF0BFFC, 1'b0, 1'b1);
    do_acc("R7", 24'h000100, 1'b1, 1'b1);
    do_acc("R7", 24'h7FFFFC, 1'b1, 1'b1);
    do_acc("R8", 24'h800000, 1'b0, 1'b1);
    do_acc("R8", 24'hFC0000, 1'b1, 1'b1);
    do_acc("R8", 24'hEFFFFC, 1'b0, 1'b1);
    // R5 control access arms write protection; R6 effects
    do_acc("R5", 24'hF40000, 1'b0, 1'b1);
    do_acc("R6", 24'h000100, 1'b1, 1'b1);
    do_acc("R6", 24'h000100, 1'b0, 1'b1);
    do_acc("R6", 24'h00BFFC, 1'b1, 1'b1);
    do_acc("R6", 24'h00C000, 1'b1, 1'b1);
    do_acc("R5", 24'hFBFFFC, 1'b1, 1'b1);
    // R10 flags stay set through further traffic
    do_acc("R10", 24'h000000, 1'b0, 1'b1);
    do_acc("R10", 24'h000200, 1'b1, 1'b1);
    // R10 reset clears both flags
    do_reset();
    do_acc("R10", 24'h000000, 1'b0, 1'b1);
    do_acc("R10", 24'hFF0000, 1'b0, 1'b1);
    do_acc("R10", 24'h000100, 1'b1, 1'b1);
    // Random traffic with occasional resets
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 300) == 0) do_reset();
      do_acc("", pick_addr($urandom), 1'($urandom), (($urandom % 8) != 0));
    end
    @(negedge clk);
    acc_valid = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule